// File: doc/BRIEF.md
# Two-Stage Pipelined Accumulator Core with Result Forwarding

This block is a compact integer core built as a two-stage pipeline. The first stage takes the instruction word returned by the instruction memory. It decodes the word, reads two source registers and runs the single ALU. It also resolves branches and issues any data-memory access. The second stage does no arithmetic. A multiplexer picks either the accumulator register, which holds the ALU result of the older instruction, or the word the data memory returned. That value goes onto an internal result bus and is written into the register file at the next clock edge. The ALU therefore always belongs to the instruction in the first stage.

Instruction and data memories are separate ports, so a fetch and a data access can fall in the same cycle. Both memories sit outside the block and answer one cycle after the address is presented. An instruction may read the register that the instruction directly ahead of it is writing. In that case the operand is taken from the result bus rather than from the register file, and the dependent instruction runs without a stall. A taken branch or jump redirects the fetch address. The one word already fetched behind it is discarded.

A three-state control machine sequences the first stage. BOOT covers the cycle after reset in which no fetched word is valid yet. RUN executes the word in stage one. SQUASH discards the word fetched behind a redirect. The transitions are: BOOT to RUN ("first word"); RUN to RUN ("fall through"); RUN to SQUASH ("redirect"), taken by a jump or a taken branch; SQUASH to RUN ("resume").

Top module: `pp2_core`

## Requirements
- R1: While reset is low and in the first cycle after it: no write-back, no data-memory read or write, and the fetch address is 0. All registers read as 0 after reset.
- R2: Instruction word (21 bits at default widths): opcode [20:17], rd [16:14], rs1 [13:11], rs2 [10:8], imm [7:0]. Opcode 1 ADD writes rs1+rs2 to rd. Opcode 2 SUB writes rs1-rs2 to rd. Both wrap modulo 2^DATA_W. Opcode 3 LDI writes the zero-extended imm to rd.
- R3: The data address is (rs1 + imm) mod 2^DADDR_W. Opcode 4 LD reads that address and writes the returned word to rd. Opcode 5 ST writes rs2 to that address at the clock edge. A load after a store to the same address sees the stored value.
- R4: Memories answer one cycle after the address. In straight-line code the fetch address rises by one every cycle, and one instruction retires per cycle.
- R5: Each register-writing instruction shows its rd and result on the write-back port exactly once, in program order. The register file takes the value at the end of that cycle.
- R6: An instruction reading the register written by the instruction directly ahead uses the new value without a stall. With r1=2, r2=5, r3=8, r4=9, the pair r3=r1+r2 then r5=r3+r4 leaves r3=7 and r5=16.
- R7: A loaded word is forwarded the same way to the instruction right after the load, without a stall.
- R8: Opcode 7 JMP and a taken opcode 6 BEQ (taken when rs1 equals rs2) load imm into the fetch address on the next edge. The word fetched behind them neither writes a register nor touches data memory. This costs exactly one cycle.
- R9: A BEQ that is not taken costs no extra cycle, and execution continues at the next word.
- R10: The data-memory read bus has no effect on any result unless a load is in the second stage.
- R11: The store data of ST is forwarded from the instruction directly ahead.
- R12: Opcodes 0 and 8 to 15 are no-ops: no register write, no memory access, no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | PC_W | Instruction fetch address |
| imem_rdata | input | INSTR_W | Instruction word for the address of the previous cycle |
| dmem_addr | output | DADDR_W | Data memory address |
| dmem_re | output | 1 | Data read request; word returns next cycle |
| dmem_rdata | input | DATA_W | Data read word |
| dmem_we | output | 1 | Data write strobe, taken at the clock edge |
| dmem_wdata | output | DATA_W | Data write word |
| wb_en | output | 1 | Register write-back this cycle |
| wb_reg | output | REG_AW | Register being written |
| wb_data | output | DATA_W | Value being written (result bus) |

## Verification
Two things can meet in one cycle. The register file may be written for the older instruction while the younger instruction reads that same register, either through ALU results or through load data. A redirect may also coincide with a fetch that has to be discarded. Directed sequences build back-to-back dependencies and branch chains. Seeded random programs bias source registers toward the previous destination and mix in forward branches and stores. Every write-back, the final registers and the final data memory are compared against an instruction-at-a-time model in the bench. Retire spacing shows whether a cycle was lost or a squashed word slipped through.

// File: rtl/pp2_pkg.sv
package pp2_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_NOP = 4'd0,
        OPC_ADD = 4'd1,
        OPC_SUB = 4'd2,
        OPC_LDI = 4'd3,
        OPC_LD  = 4'd4,
        OPC_ST  = 4'd5,
        OPC_BEQ = 4'd6,
        OPC_JMP = 4'd7
    } opc_e;

    typedef enum logic [1:0] {
        S_BOOT   = 2'd0,
        S_RUN    = 2'd1,
        S_SQUASH = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        FN_ADD   = 2'd0,
        FN_SUB   = 2'd1,
        FN_PASSB = 2'd2
    } alu_fn_e;

    typedef struct packed {
        logic    wr_reg;
        logic    rd_mem;
        logic    wr_mem;
        logic    br_eq;
        logic    br_jmp;
        logic    use_a;
        logic    use_b;
        logic    imm_b;
        alu_fn_e fn;
    } uop_t;

    function automatic uop_t decode_op(input logic [OP_W-1:0] code);
        uop_t u;
        u    = '0;
        u.fn = FN_ADD;
        case (code)
            OPC_ADD: begin
                u.wr_reg = 1'b1; u.use_a = 1'b1; u.use_b = 1'b1;
            end
            OPC_SUB: begin
                u.wr_reg = 1'b1; u.use_a = 1'b1; u.use_b = 1'b1; u.fn = FN_SUB;
            end
            OPC_LDI: begin
                u.wr_reg = 1'b1; u.imm_b = 1'b1; u.fn = FN_PASSB;
            end
            OPC_LD: begin
                u.wr_reg = 1'b1; u.rd_mem = 1'b1; u.use_a = 1'b1; u.imm_b = 1'b1;
            end
            OPC_ST: begin
                u.wr_mem = 1'b1; u.use_a = 1'b1; u.use_b = 1'b1; u.imm_b = 1'b1;
            end
            OPC_BEQ: begin
                u.br_eq = 1'b1; u.use_a = 1'b1; u.use_b = 1'b1;
            end
            OPC_JMP: begin
                u.br_jmp = 1'b1;
            end
            default: ;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/pp2_decode.sv
module pp2_decode
    import pp2_pkg::*;
#(
    parameter int REG_AW = 3,
    parameter int IMM_W  = 8,
    localparam int INSTR_W = OP_W + 3 * REG_AW + IMM_W
) (
    input  logic [INSTR_W-1:0] instr,
    output uop_t               uop,
    output logic [REG_AW-1:0]  rd,
    output logic [REG_AW-1:0]  rs1,
    output logic [REG_AW-1:0]  rs2,
    output logic [IMM_W-1:0]   imm
);
    localparam int RS2_LO = IMM_W;
    localparam int RS1_LO = RS2_LO + REG_AW;
    localparam int RD_LO  = RS1_LO + REG_AW;
    localparam int OP_LO  = RD_LO + REG_AW;

    always_comb begin
        uop = decode_op(instr[OP_LO +: OP_W]);
        rd  = instr[RD_LO +: REG_AW];
        rs1 = instr[RS1_LO +: REG_AW];
        rs2 = instr[RS2_LO +: REG_AW];
        imm = instr[0 +: IMM_W];
    end
endmodule

// File: rtl/pp2_alu.sv
module pp2_alu
    import pp2_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              eq
);
    always_comb begin
        eq = (a == b);
        unique case (fn)
            FN_ADD:   y = a + b;
            FN_SUB:   y = a - b;
            FN_PASSB: y = b;
            default:  y = a + b;
        endcase
    end
endmodule

// File: rtl/pp2_regfile.sv
module pp2_regfile #(
    parameter int DATA_W = 16,
    parameter int REG_AW = 3,
    localparam int REG_N = 1 << REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] raddr_a,
    input  logic [REG_AW-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    logic [REG_N-1:0][DATA_W-1:0] cells;

    for (genvar gi = 0; gi < REG_N; gi++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == REG_AW'(gi))) begin
                q <= wdata;
            end
        end
        assign cells[gi] = q;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/pp2_ctrl.sv
module pp2_ctrl
    import pp2_pkg::*;
#(
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_a,
    input  logic              use_b,
    input  logic              br_eq,
    input  logic              br_jmp,
    input  logic              ops_equal,
    input  logic [REG_AW-1:0] rs1,
    input  logic [REG_AW-1:0] rs2,
    input  logic              s2_wr,
    input  logic [REG_AW-1:0] s2_rd,
    output ctl_state_e        state_q,
    output logic              s1_valid,
    output logic              redirect,
    output logic              fwd_a,
    output logic              fwd_b
);
    ctl_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        s1_valid = 1'b0;
        redirect = 1'b0;
        unique case (state_q)
            S_BOOT: begin
                state_d = S_RUN;                       // first word
            end
            S_RUN: begin
                s1_valid = 1'b1;
                redirect = br_jmp | (br_eq & ops_equal);
                state_d  = redirect ? S_SQUASH : S_RUN; // redirect / fall through
            end
            S_SQUASH: begin
                state_d = S_RUN;                       // resume
            end
            default: begin
                state_d = S_BOOT;
            end
        endcase
        // read-after-write on the directly older instruction: take the result bus
        fwd_a = s2_wr & use_a & (s2_rd == rs1);
        fwd_b = s2_wr & use_b & (s2_rd == rs2);
    end
endmodule

// File: rtl/pp2_core.sv
module pp2_core
    import pp2_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_AW  = 3,
    parameter int PC_W    = 8,
    parameter int DADDR_W = 6,
    localparam int INSTR_W = OP_W + 3 * REG_AW + PC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic               dmem_re,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic               dmem_we,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               wb_en,
    output logic [REG_AW-1:0]  wb_reg,
    output logic [DATA_W-1:0]  wb_data
);
    // stage-one decode
    uop_t              uop;
    logic [REG_AW-1:0] rd, rs1, rs2;
    logic [PC_W-1:0]   s1_imm;

    // control
    ctl_state_e ctl_state;
    logic       s1_valid, redirect, fwd_a, fwd_b;

    // operands and ALU
    logic [DATA_W-1:0] rf_a, rf_b, opa, opb, alu_b, alu_y;
    logic              ops_equal;

    // stage-two state
    logic [PC_W-1:0]   pc_q;
    logic              s2_wr_q, s2_ld_q;
    logic [REG_AW-1:0] s2_rd_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] res_bus;

    pp2_decode #(.REG_AW(REG_AW), .IMM_W(PC_W)) u_dec (
        .instr (imem_rdata),
        .uop   (uop),
        .rd    (rd),
        .rs1   (rs1),
        .rs2   (rs2),
        .imm   (s1_imm)
    );

    pp2_ctrl #(.REG_AW(REG_AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_a     (uop.use_a),
        .use_b     (uop.use_b),
        .br_eq     (uop.br_eq),
        .br_jmp    (uop.br_jmp),
        .ops_equal (ops_equal),
        .rs1       (rs1),
        .rs2       (rs2),
        .s2_wr     (s2_wr_q),
        .s2_rd     (s2_rd_q),
        .state_q   (ctl_state),
        .s1_valid  (s1_valid),
        .redirect  (redirect),
        .fwd_a     (fwd_a),
        .fwd_b     (fwd_b)
    );

    pp2_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (s2_wr_q),
        .waddr   (s2_rd_q),
        .wdata   (res_bus),
        .raddr_a (rs1),
        .raddr_b (rs2),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    // second stage: a mux, not the ALU; memory data only passes for a load
    assign res_bus = s2_ld_q ? dmem_rdata : acc_q;

    assign opa   = fwd_a ? res_bus : rf_a;
    assign opb   = fwd_b ? res_bus : rf_b;
    assign alu_b = uop.imm_b ? DATA_W'(s1_imm) : opb;

    pp2_alu #(.DATA_W(DATA_W)) u_alu (
        .fn (uop.fn),
        .a  (opa),
        .b  (alu_b),
        .y  (alu_y),
        .eq (ops_equal)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            s2_wr_q <= 1'b0;
            s2_ld_q <= 1'b0;
            s2_rd_q <= '0;
            acc_q   <= '0;
        end else begin
            pc_q    <= redirect ? s1_imm : pc_q + 1'b1;
            s2_wr_q <= s1_valid & uop.wr_reg;
            s2_ld_q <= s1_valid & uop.rd_mem;
            s2_rd_q <= rd;
            if (s1_valid) begin
                acc_q <= alu_y;
            end
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y[DADDR_W-1:0];
    assign dmem_re    = s1_valid & uop.rd_mem;
    assign dmem_we    = s1_valid & uop.wr_mem;
    assign dmem_wdata = opb;
    assign wb_en      = s2_wr_q;
    assign wb_reg     = s2_rd_q;
    assign wb_data    = res_bus;
endmodule

// File: rtl/pp2_core_chk.sv
module pp2_core_chk
    import pp2_pkg::*;
#(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input ctl_state_e      state,
    input logic            redirect,
    input logic [PC_W-1:0] target,
    input logic [PC_W-1:0] imem_addr,
    input logic            dmem_re,
    input logic            dmem_we,
    input logic            wb_en
);
    assert_boot_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BOOT) |-> (!dmem_re && !dmem_we));

    assert_mem_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_re && dmem_we));

    assert_fetch_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> (imem_addr == PC_W'($past(imem_addr) + 1'b1)));

    assert_redirect_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (imem_addr == $past(target)));

    assert_squash_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SQUASH) |-> (!dmem_re && !dmem_we && !redirect));

    assert_squash_nowb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SQUASH) |=> !wb_en);
endmodule

bind pp2_core pp2_core_chk #(.PC_W(PC_W)) u_pp2_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (ctl_state),
    .redirect  (redirect),
    .target    (s1_imm),
    .imem_addr (imem_addr),
    .dmem_re   (dmem_re),
    .dmem_we   (dmem_we),
    .wb_en     (wb_en)
);

// File: tb/pp2_core_bench.sv
module pp2_core_bench;
    import pp2_pkg::*;

    localparam int DATA_W  = 16;
    localparam int REG_AW  = 3;
    localparam int PC_W    = 8;
    localparam int DADDR_W = 6;
    localparam int INSTR_W = OP_W + 3 * REG_AW + PC_W;
    localparam int REG_N   = 1 << REG_AW;
    localparam int IM_N    = 1 << PC_W;
    localparam int DM_N    = 1 << DADDR_W;
    localparam int EXP_MAX = 128;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic [PC_W-1:0]    imem_addr;
    logic [INSTR_W-1:0] imem_rdata;
    logic [DADDR_W-1:0] dmem_addr;
    logic               dmem_re;
    logic [DATA_W-1:0]  dmem_rdata;
    logic               dmem_we;
    logic [DATA_W-1:0]  dmem_wdata;
    logic               wb_en;
    logic [REG_AW-1:0]  wb_reg;
    logic [DATA_W-1:0]  wb_data;

    pp2_core #(.DATA_W(DATA_W), .REG_AW(REG_AW), .PC_W(PC_W), .DADDR_W(DADDR_W)) u_pp2_core (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    logic [INSTR_W-1:0] imem [IM_N];
    logic [DATA_W-1:0]  dmem [DM_N];

    // memories: one-cycle read; garbage on the data bus when nothing is read (R10)
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        if (dmem_re) dmem_rdata <= dmem[dmem_addr];
        else         dmem_rdata <= DATA_W'($urandom) | DATA_W'(1);
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference model state
    logic [DATA_W-1:0] m_regs [REG_N];
    logic [DATA_W-1:0] m_dmem [DM_N];
    logic [REG_AW-1:0] exp_rd [EXP_MAX];
    logic [DATA_W-1:0] exp_val [EXP_MAX];
    int exp_n;

    // observed state
    logic [DATA_W-1:0] shadow [REG_N];
    int wr_cyc [EXP_MAX];
    int got_n, run_len, max_run;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // write-back monitor, sampled mid-cycle (R5)
    always @(negedge clk) begin
        if (mon_on) begin
            if (wb_en) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
                shadow[wb_reg] = wb_data;
                checks++;
                if (got_n >= exp_n) begin
                    fails++;
                    $display("FAIL R5 unexpected write r%0d: got %h expected none", wb_reg, wb_data);
                end else if (wb_reg !== exp_rd[got_n] || wb_data !== exp_val[got_n]) begin
                    fails++;
                    $display("FAIL R5 write %0d: got r%0d=%h expected r%0d=%h",
                             got_n, wb_reg, wb_data, exp_rd[got_n], exp_val[got_n]);
                end
                if (got_n < EXP_MAX) wr_cyc[got_n] = cyc;
                got_n++;
            end else begin
                run_len = 0;
            end
        end
    end

    function automatic logic [INSTR_W-1:0] enc(input int op, input int rd, input int rs1,
                                               input int rs2, input int imm);
        return {OP_W'(op), REG_AW'(rd), REG_AW'(rs1), REG_AW'(rs2), PC_W'(imm)};
    endfunction

    // instruction-at-a-time model; returns a cycle budget
    task automatic model_run(output int cost);
        int pc;
        int steps;
        pc = 0; steps = 0; cost = 0; exp_n = 0;
        for (int i = 0; i < REG_N; i++) m_regs[i] = '0;
        while (steps < 1000) begin
            logic [INSTR_W-1:0] w;
            logic [OP_W-1:0]    op;
            logic [REG_AW-1:0]  rd, rs1, rs2;
            logic [PC_W-1:0]    imm;
            logic [DATA_W-1:0]  a, b, v;
            logic [DADDR_W-1:0] ad;
            int npc;
            bit wr;
            w   = imem[pc];
            op  = w[INSTR_W-1 -: OP_W];
            rd  = w[PC_W + 2*REG_AW +: REG_AW];
            rs1 = w[PC_W + REG_AW +: REG_AW];
            rs2 = w[PC_W +: REG_AW];
            imm = w[PC_W-1:0];
            a = m_regs[rs1]; b = m_regs[rs2];
            ad = DADDR_W'(a + DATA_W'(imm));
            npc = (pc + 1) % IM_N; wr = 1'b0; v = '0;
            case (op)
                4'd1: begin v = a + b; wr = 1'b1; end
                4'd2: begin v = a - b; wr = 1'b1; end
                4'd3: begin v = DATA_W'(imm); wr = 1'b1; end
                4'd4: begin v = m_dmem[ad]; wr = 1'b1; end
                4'd5: m_dmem[ad] = b;
                4'd6: if (a == b) begin npc = int'(imm); cost++; end
                4'd7: begin
                    if (int'(imm) == pc) break;
                    npc = int'(imm); cost++;
                end
                default: ;
            endcase
            if (wr) begin
                m_regs[rd] = v;
                if (exp_n < EXP_MAX) begin exp_rd[exp_n] = rd; exp_val[exp_n] = v; end
                exp_n++;
            end
            pc = npc; steps++; cost++;
        end
    endtask

    task automatic run_prog(input string name, input bit rst_chk);
        int cost;
        rst_n  = 1'b0;
        mon_on = 1'b0;
        for (int i = 0; i < DM_N; i++) m_dmem[i] = dmem[i];
        model_run(cost);
        for (int i = 0; i < REG_N; i++) shadow[i] = '0;
        got_n = 0; run_len = 0; max_run = 0;
        repeat (3) @(negedge clk);
        if (rst_chk) begin
            chk(wb_en == 1'b0, "R1", "wb_en in reset", 32'(wb_en), 0);
            chk(!dmem_re && !dmem_we, "R1", "mem access in reset", {dmem_re, dmem_we}, 0);
            chk(imem_addr == '0, "R1", "fetch address in reset", 32'(imem_addr), 0);
        end
        rst_n  = 1'b1;
        mon_on = 1'b1;
        if (rst_chk) begin
            #1;
            chk(!wb_en && !dmem_re && !dmem_we, "R1", "first cycle quiet",
                {wb_en, dmem_re, dmem_we}, 0);
        end
        repeat (cost + 8) @(negedge clk);
        mon_on = 1'b0;
        chk(got_n == exp_n, "R5", {name, " write count"}, got_n, exp_n);
        for (int i = 0; i < REG_N; i++)
            chk(shadow[i] == m_regs[i], "R2", {name, " final register"}, shadow[i], m_regs[i]);
        for (int i = 0; i < DM_N; i++)
            if (dmem[i] != m_dmem[i])
                chk(1'b0, "R3", {name, " data memory word"}, dmem[i], m_dmem[i]);
        checks++;
    endtask

    task automatic clear_imem();
        for (int i = 0; i < IM_N; i++) imem[i] = '0;
    endtask

    initial begin
        void'($urandom(32'h5eed_2a11));
        for (int i = 0; i < DM_N; i++) dmem[i] = '0;

        // P1: forwarding example, back-to-back retire, store data forwarded
        clear_imem();
        imem[0] = enc(3, 1, 0, 0, 2);
        imem[1] = enc(3, 2, 0, 0, 5);
        imem[2] = enc(3, 3, 0, 0, 8);
        imem[3] = enc(3, 4, 0, 0, 9);
        imem[4] = enc(3, 5, 0, 0, 4);
        imem[5] = enc(1, 3, 1, 2, 0);
        imem[6] = enc(1, 5, 3, 4, 0);
        imem[7] = enc(5, 0, 0, 5, 10);
        imem[8] = enc(7, 0, 0, 0, 8);
        run_prog("P1", 1'b1);
        chk(shadow[3] == 16'd7,  "R6", "r3 after add", shadow[3], 7);
        chk(shadow[5] == 16'd16, "R6", "r5 dependent add", shadow[5], 16);
        chk(max_run == 7, "R4", "consecutive retire cycles", max_run, 7);
        chk(dmem[10] == 16'd16, "R11", "stored forwarded data", dmem[10], 16);

        // P2: load-use forwarding, store then load, SUB wrap
        clear_imem();
        dmem[5] = 16'd100;
        imem[0] = enc(4, 1, 0, 0, 5);
        imem[1] = enc(1, 2, 1, 1, 0);
        imem[2] = enc(3, 3, 0, 0, 7);
        imem[3] = enc(5, 0, 0, 3, 6);
        imem[4] = enc(4, 4, 0, 0, 6);
        imem[5] = enc(2, 5, 4, 2, 0);
        imem[6] = enc(7, 0, 0, 0, 6);
        run_prog("P2", 1'b0);
        chk(shadow[2] == 16'd200, "R7", "add of loaded word", shadow[2], 200);
        chk(shadow[4] == 16'd7, "R3", "load after store", shadow[4], 7);
        chk(shadow[5] == 16'hFF3F, "R2", "sub wraps", shadow[5], 32'hFF3F);

        // P3: not-taken branch, jump, taken branch with forwarded operand
        clear_imem();
        imem[0] = enc(3, 1, 0, 0, 1);
        imem[1] = enc(6, 0, 1, 0, 7);
        imem[2] = enc(7, 0, 0, 0, 4);
        imem[3] = enc(3, 6, 0, 0, 99);
        imem[4] = enc(3, 2, 0, 0, 3);
        imem[5] = enc(6, 0, 2, 2, 7);
        imem[6] = enc(3, 7, 0, 0, 55);
        imem[7] = enc(3, 3, 0, 0, 4);
        imem[8] = enc(7, 0, 0, 0, 8);
        run_prog("P3", 1'b0);
        chk(shadow[6] == '0 && shadow[7] == '0, "R8", "squashed words wrote", {shadow[6], shadow[7]}, 0);
        chk(wr_cyc[1] - wr_cyc[0] == 4, "R9", "spacing across untaken branch", wr_cyc[1] - wr_cyc[0], 4);
        chk(wr_cyc[2] - wr_cyc[1] == 3, "R8", "taken branch penalty", wr_cyc[2] - wr_cyc[1], 3);
        chk(shadow[2] == 16'd3 && shadow[3] == 16'd4, "R9", "fall-through results", {shadow[2], shadow[3]}, {16'd3, 16'd4});

        // P4: undefined opcode is a no-op; registers cleared by reset
        clear_imem();
        imem[0] = enc(3, 1, 0, 0, 9);
        imem[1] = enc(11, 1, 1, 1, 8'h55);
        imem[2] = enc(1, 2, 1, 1, 0);
        imem[3] = enc(1, 4, 5, 5, 0);
        imem[4] = enc(7, 0, 0, 0, 4);
        run_prog("P4", 1'b0);
        chk(shadow[1] == 16'd9 && shadow[2] == 16'd18, "R12", "no-op left r1", {shadow[1], shadow[2]}, {16'd9, 16'd18});
        chk(got_n == 3, "R12", "writes with no-op", got_n, 3);
        chk(shadow[4] == '0, "R1", "register after reset", shadow[4], 0);

        // random programs: dependent chains, loads, stores, forward branches (R10 via bus garbage)
        for (int p = 0; p < 30; p++) begin
            int len;
            int prev_rd;
            clear_imem();
            for (int i = 0; i < DM_N; i++) dmem[i] = DATA_W'($urandom);
            len = 20 + int'($urandom % 10);
            prev_rd = 0;
            for (int i = 0; i < len; i++) begin
                int sel, rd, r1, r2, tgt;
                sel = int'($urandom % 16);
                rd  = int'($urandom % REG_N);
                r1  = ($urandom % 2 == 0) ? prev_rd : int'($urandom % REG_N);
                r2  = ($urandom % 2 == 0) ? prev_rd : int'($urandom % REG_N);
                tgt = i + 1 + int'($urandom % 3);
                if (tgt > len) tgt = len;
                if (sel < 4)       imem[i] = enc(1, rd, r1, r2, 0);
                else if (sel < 6)  imem[i] = enc(2, rd, r1, r2, 0);
                else if (sel < 9)  imem[i] = enc(3, rd, 0, 0, int'($urandom % 256));
                else if (sel < 11) imem[i] = enc(4, rd, r1, 0, int'($urandom % 256));
                else if (sel < 13) imem[i] = enc(5, 0, r1, r2, int'($urandom % 256));
                else if (sel < 14) imem[i] = enc(6, 0, r1, r2, tgt);
                else if (sel < 15) imem[i] = enc(7, 0, 0, 0, tgt);
                else               imem[i] = enc(8 + int'($urandom % 8), rd, r1, r2, int'($urandom % 256));
                if (sel < 11) prev_rd = rd;
            end
            imem[len] = enc(7, 0, 0, 0, len);
            run_prog("RND", 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule